// File: doc/BRIEF.md
# Bounds-Checked Byte-Addressed Data Memory

This block is a small data memory addressed in bytes. A load returns a byte, a halfword or a word, and a store writes one of those three sizes. The read port is combinational: an address, an access size and a signedness flag go in, and the loaded value comes back in the same cycle. The write port is synchronous: an enable, an address, a size and a data word are sampled on the rising clock edge. Multi-byte values are kept little-endian, so the least significant byte sits at the lowest address. No alignment is required.

Each port checks every access against the memory capacity. The read side and the write side each have their own out-of-range flag. A write that is out of range is dropped and leaves the memory as it was. A read that is out of range returns zero. An execution core drives the block directly. It uses the two trap flags to stop the program.

The capacity `DEPTH` is given in bytes. It must be a power of two and at least 4. The memory contents are not cleared by reset. While reset is high, writes are ignored.

Top module: `lmem_top`

## Requirements
- R1: The size code selects the access width on both ports: 0 is one byte, 1 is two bytes, 2 is four bytes, and the reserved code 3 behaves as four bytes.
- R2: Storage is little-endian: the byte at address A holds bits 7:0 of an access at A, the byte at A+1 holds bits 15:8, and so on.
- R3: A read returns data in the same cycle its address is presented, and a write becomes visible to reads in the cycle after the clock edge that accepts it.
- R4: A word stored at any in-range address and then loaded as a word returns the same 32-bit value (for example 0xDEADBEEF).
- R5: With the signed flag at 1, byte loads copy bit 7 into bits 31:8 and halfword loads copy bit 15 into bits 31:16.
- R6: With the signed flag at 0, byte loads return zero in bits 31:8 and halfword loads return zero in bits 31:16.
- R7: The read trap is 1 exactly when the read address plus the access width minus one is at or above DEPTH, with no wraparound of the 32-bit address. While the read trap is 1, the read data is zero.
- R8: The write trap is 1 exactly when the write enable is 1 and the write address plus the access width minus one is at or above DEPTH. The write trap is 0 whenever the write enable is 0.
- R9: A write that raises the write trap changes no byte of the memory.
- R10: A write presented while reset is high changes no byte of the memory.
- R11: A byte or halfword store changes only the bytes it addresses, and leaves the neighbouring bytes of the same word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; blocks writes |
| rd_addr | input | ADDR_W | Load byte address |
| rd_size | input | 2 | Load size code (0 byte, 1 half, 2 word) |
| rd_signed | input | 1 | 1 sign-extends a sub-word load, 0 zero-extends it |
| rd_data | output | 32 | Loaded value, combinational |
| rd_trap | output | 1 | Load is out of range |
| wr_en | input | 1 | Store request |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | 2 | Store size code (0 byte, 1 half, 2 word) |
| wr_data | input | 32 | Store value; the low bytes are used for sub-word stores |
| wr_trap | output | 1 | Store is out of range |

## Verification
The embedded properties check several rules on every cycle. They check that sub-word loads are extended correctly for the flag given, that a trapped load returns zero, and that addresses wholly beyond the memory always trap on read. They also check that an idle write port never flags a trap, and that a trapped store leaves the addressed bytes unchanged. Other behaviour can only be seen in the bench's scenarios. This covers the little-endian byte placement, round-trips through stores of each size, the exact trap boundary for every size, and the rule that neighbouring bytes survive a partial store. It also covers stores ignored during reset. The bench sweeps every address near and beyond the top of a 16-byte memory with all size codes and both signedness settings, and compares each result against an arithmetic byte model.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lmem_size_e;

  // Number of bytes touched by an access of the given size code (R1).
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (lmem_size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lmem_bounds.sv
module lmem_bounds
  import lmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              oob
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [2:0]      nbytes;
  logic [ADDR_W:0] last_byte;

  // One extra bit keeps the sum from wrapping at the top of the address space.
  always_comb begin
    nbytes    = size_bytes(size);
    last_byte = {1'b0, addr} + {{(ADDR_W-2){1'b0}}, nbytes - 3'd1};
    oob       = (last_byte >= LIMIT);
  end

endmodule

// File: rtl/lmem_store.sv
module lmem_store
  import lmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [2:0]           wr_bytes,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WORD_BITS-1:0] rd_raw
);

  logic [7:0] mem [DEPTH];

  // Write: one lane per byte of the word, lane k at address idx+k (R2, R11).
  always_ff @(posedge clk) begin
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (we && (3'(k) < wr_bytes)) begin
        mem[wr_idx + IDX_W'(k)] <= wr_data[8*k +: 8];
      end
    end
  end

  // Read: four byte taps, assembled little-endian; combinational (R3).
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_tap
    assign rd_raw[8*g +: 8] = mem[rd_idx + IDX_W'(g)];
  end

endmodule

// File: rtl/lmem_extend.sv
module lmem_extend
  import lmem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_BITS-1:0] raw,
  input  logic [1:0]           size,
  input  logic                 sext,
  input  logic                 kill,
  output logic [WORD_BITS-1:0] data
);

  logic fill;

  always_comb begin
    fill = 1'b0;
    data = raw;
    case (lmem_size_e'(size))
      SZ_BYTE: begin
        fill = sext & raw[7];
        data = {{(WORD_BITS-8){fill}}, raw[7:0]};
      end
      SZ_HALF: begin
        fill = sext & raw[15];
        data = {{(WORD_BITS-16){fill}}, raw[15:0]};
      end
      default: data = raw;
    endcase
    if (kill) data = '0;
  end

  AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (rst)
    (!kill && size == 2'd0 && sext) |-> (data[31:8] == {24{data[7]}})); // R5
  AST_HALF_SEXT: assert property (@(posedge clk) disable iff (rst)
    (!kill && size == 2'd1 && sext) |-> (data[31:16] == {16{data[15]}})); // R5
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (size == 2'd0 && !sext) |-> (data[31:8] == 24'd0)); // R6
  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (size == 2'd1 && !sext) |-> (data[31:16] == 16'd0)); // R6

endmodule

// File: rtl/lmem_top.sv
module lmem_top
  import lmem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [1:0]           rd_size,
  input  logic                 rd_signed,
  output logic [WORD_BITS-1:0] rd_data,
  output logic                 rd_trap,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [1:0]           wr_size,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic                 wr_trap
);

  localparam int IDX_W = $clog2(DEPTH);

  logic                 wr_oob;
  logic                 wr_go;
  logic [WORD_BITS-1:0] raw;

  lmem_bounds #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rd_chk (
    .addr (rd_addr),
    .size (rd_size),
    .oob  (rd_trap)
  );

  lmem_bounds #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wr_chk (
    .addr (wr_addr),
    .size (wr_size),
    .oob  (wr_oob)
  );

  assign wr_trap = wr_en & wr_oob;
  assign wr_go   = wr_en & ~wr_oob & ~rst;

  lmem_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .we       (wr_go),
    .wr_idx   (wr_addr[IDX_W-1:0]),
    .wr_bytes (size_bytes(wr_size)),
    .wr_data  (wr_data),
    .rd_idx   (rd_addr[IDX_W-1:0]),
    .rd_raw   (raw)
  );

  lmem_extend u_ext (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw),
    .size (rd_size),
    .sext (rd_signed),
    .kill (rd_trap),
    .data (rd_data)
  );

  AST_RD_TRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_trap |-> (rd_data == '0)); // R7
  AST_RD_FAR_TRAP: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= ADDR_W'(DEPTH)) |-> rd_trap); // R7
  AST_WR_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_trap); // R8
  AST_WR_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_trap) |=> ($stable(rd_addr) -> $stable(raw))); // R9

endmodule

// File: tb/tb_lmem_top.sv
module tb_lmem_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DEPTH      = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [1:0]        rd_size = '0;
  logic              rd_signed = 1'b0;
  logic [31:0]       rd_data;
  logic              rd_trap;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [1:0]        wr_size = '0;
  logic [31:0]       wr_data = '0;
  logic              wr_trap;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [DEPTH];

  lmem_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .rd_size(rd_size), .rd_signed(rd_signed),
    .rd_data(rd_data), .rd_trap(rd_trap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_trap(wr_trap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit is_oob(input logic [31:0] a, input logic [1:0] s);
    return (longint'(a) + longint'(nbytes(s)) - 1) >= longint'(DEPTH);
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] a, input logic [1:0] s, input logic sg);
    logic [31:0] v;
    int w;
    w = nbytes(s);
    v = '0;
    if (is_oob(a, s)) return '0;
    for (int k = 0; k < w; k++) v[8*k +: 8] = model[int'(a) + k];
    if (sg && w < 4 && v[8*w-1]) v = v | ~((32'd1 << (8*w)) - 32'd1);
    return v;
  endfunction

  task automatic do_read(input logic [31:0] a, input logic [1:0] s, input logic sg,
                         input string tag, output logic [31:0] got);
    @(negedge clk);
    rd_addr = a; rd_size = s; rd_signed = sg;
    #1;
    got = rd_data;
    check(tag, rd_data, exp_load(a, s, sg));
    check("R7 read trap", {31'd0, rd_trap}, {31'd0, is_oob(a, s)});
  endtask

  task automatic do_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    bit oob;
    oob = is_oob(a, s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
    #1;
    check("R8 write trap", {31'd0, wr_trap}, {31'd0, oob});
    @(posedge clk);
    if (!oob && !rst)
      for (int k = 0; k < nbytes(s); k++) model[int'(a) + k] = d[8*k +: 8];
    #1;
    wr_en = 1'b0;
  endtask

  task automatic sweep();
    logic [31:0] got;
    string tag;
    for (int a = 0; a < DEPTH + 4; a++)
      for (int s = 0; s < 4; s++)
        for (int sg = 0; sg < 2; sg++) begin
          if (s == 3) tag = "R1 reserved size";
          else if (s == 2) tag = "R4 word load";
          else if (sg == 1) tag = "R5 signed load";
          else tag = "R6 unsigned load";
          do_read(32'(a), 2'(s), sg[0], tag, got);
        end
    do_read(32'hFFFF_FFFF, 2'd0, 1'b0, "R7 top byte", got);
    do_read(32'hFFFF_FFFD, 2'd2, 1'b1, "R7 wrap word", got);
    do_read(32'h8000_0000, 2'd1, 1'b0, "R7 far half", got);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 idle trap in reset", {31'd0, wr_trap}, 32'd0);
    rst = 1'b0;

    // Byte fill with values spanning both halves of the sign range
    for (int a = 0; a < DEPTH; a++) do_write(32'(a), 2'd0, 32'((a * 37 + 5) & 255));
    sweep();

    // Halfword stores at even and odd addresses (R11 via model)
    for (int a = 0; a < DEPTH - 1; a += 3) do_write(32'(a), 2'd1, 32'(a * 4099 + 32'h8001));
    sweep();

    // Word stores at unaligned addresses
    for (int a = 1; a < DEPTH - 3; a += 4) do_write(32'(a), 2'd2, 32'h9ABC_0000 + 32'(a * 32'h1357));
    sweep();

    // Word round trip and byte order
    do_write(32'd4, 2'd2, 32'hDEAD_BEEF);
    do_read(32'd4, 2'd2, 1'b0, "R3 next-cycle visibility", got);
    check("R4 round trip", got, 32'hDEAD_BEEF);
    do_read(32'd4, 2'd0, 1'b0, "R2 low byte", got);
    check("R2 lowest address", got, 32'h0000_00EF);
    do_read(32'd7, 2'd0, 1'b1, "R2 high byte", got);
    check("R2 highest address", got, 32'hFFFF_FFDE);

    // Partial store keeps neighbours
    do_write(32'd5, 2'd0, 32'hFFFF_FF11);
    do_read(32'd4, 2'd2, 1'b0, "R11 byte merge", got);
    check("R11 neighbours kept", got, 32'hDEAD_11EF);
    do_write(32'd6, 2'd1, 32'h0000_7788);
    do_read(32'd4, 2'd2, 1'b0, "R11 half merge", got);
    check("R11 half neighbours kept", got, 32'h7788_11EF);

    // Trapped stores must leave memory untouched
    do_write(32'(DEPTH - 4), 2'd2, 32'h0102_0304);
    for (int a = DEPTH - 3; a < DEPTH + 3; a++) do_write(32'(a), 2'd2, 32'hFFFF_FFFF);
    do_write(32'(DEPTH - 1), 2'd1, 32'hFFFF_FFFF);
    do_write(32'(DEPTH), 2'd0, 32'hFFFF_FFFF);
    do_write(32'hFFFF_FFFE, 2'd2, 32'hFFFF_FFFF);
    do_read(32'(DEPTH - 4), 2'd2, 1'b0, "R9 trapped stores", got);
    check("R9 top word intact", got, 32'h0102_0304);
    do_read(32'd0, 2'd2, 1'b0, "R9 wrap target", got);
    sweep();

    // Store during reset is ignored
    do_read(32'd0, 2'd2, 1'b0, "R10 before", got);
    rst = 1'b1;
    do_write(32'd0, 2'd2, 32'h5555_5555);
    rst = 1'b0;
    do_read(32'd0, 2'd2, 1'b0, "R10 store in reset ignored", got);
    sweep();

    summary();
    $finish;
  end

endmodule